// File: doc/BRIEF.md
# Self-timed peripheral write strobe generator

This block produces the active-low chip-select pulse that a memory controller sends to a video shift-register peripheral when the CPU writes one of its registers. It runs entirely from a single fast clock (nominally 16 MHz). It divides that clock by two three times to form a bus-slot clock. The low half of the slot clock is the CPU slot and the high half belongs to video fetch and refresh.

The CPU write is recognised from the device select, read/write, data strobes and a target decode. The decoded write is registered once and then starts a strobe that is aligned to the next CPU slot. The rising edge of the strobe is the one the peripheral uses to latch the data. That edge is placed by the fast-clock slot counter alone. It does not wait for the CPU to end its bus cycle, so it arrives while the data strobes are still low. Only one strobe is issued per bus cycle. A new strobe needs the data strobes to have been seen high first.

Top module: `periph_wr_strobe`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1 and `slot_clk` is 0. The reset is applied asynchronously and released synchronously to `clk_fast`.
- R2: `slot_clk` has a period of 8 `clk_fast` cycles: 4 cycles low, then 4 cycles high. Phase 0 is the first fast cycle in which `slot_clk` is low. Phases 0 to 3 are the CPU slot.
- R3: A write request exists in a fast cycle when `dev_n`=0, `rw`=0 (0 means write), `wr_target`=1 and at least one of `uds_n`/`lds_n` is 0. A read (`rw`=1), `dev_n`=1, `wr_target`=0 or both strobes high produce no strobe.
- R4: The request is registered for one fast cycle before it is used. Let p be the phase of the first cycle with the request. If p is 0 to 6, `cs_n` goes low at phase 0 of the next CPU slot, which is 8−p cycles later. If p is 7, it goes low 9 cycles later.
- R5: Once low, `cs_n` stays low for exactly 4 fast cycles. It returns high at phase 4 even while the data strobes are still asserted.
- R6: At most one strobe is issued while the data strobes stay asserted. Another strobe needs `uds_n` and `lds_n` to have been both high for at least one fast cycle.
- R7: If the data strobes are released while `cs_n` is low, the strobe is neither shortened nor lengthened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock (nominally 16 MHz) |
| rst_n | input | 1 | Active-low power-up reset |
| dev_n | input | 1 | Active-low device-space select from the CPU side |
| rw | input | 1 | 1 = read, 0 = write |
| uds_n | input | 1 | Active-low upper data strobe |
| lds_n | input | 1 | Active-low lower data strobe |
| wr_target | input | 1 | Address decode: the access targets the peripheral |
| cs_n | output | 1 | Active-low chip-select strobe to the peripheral |
| slot_clk | output | 1 | Bus-slot clock (fast clock divided by 8) |

## Verification
The bench starts a write at each of the eight slot phases. Phase 7 is the hard case: a design that used the request without its register stage, or that started on the same cycle, would strobe one slot early there. In every case the bench checks the fall and the rise of the strobe cycle by cycle. A design that followed the CPU handshake would keep `cs_n` low while the data strobes are held for many slots. It would also cut the strobe short when the strobes drop mid-pulse, and the long-hold and short-hold cases catch both. A missing re-arm guard would show as repeated strobes during one long bus cycle. Reads, deselected accesses, a missing target decode and idle strobes must leave `cs_n` high.

// File: rtl/periph_wr_strobe_pkg.sv
package periph_wr_strobe_pkg;

  // CPU-side bus signals as seen by the strobe generator.
  typedef struct packed {
    logic dev_n;
    logic rw;
    logic uds_n;
    logic lds_n;
    logic target;
  } cpu_bus_t;

endpackage

// File: rtl/pws_reset_sync.sv
module pws_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];

endmodule

// File: rtl/pws_slot_divider.sv
module pws_slot_divider #(
  parameter int DIV_STAGES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [DIV_STAGES-1:0] phase,
  output logic                  slot_clk
);

  logic [DIV_STAGES-1:0] cnt_q, cnt_d;
  logic [DIV_STAGES:0]   carry;

  assign carry[0] = 1'b1;

  // One divide-by-two stage per bit; each toggles when all lower stages are high.
  for (genvar g = 0; g < DIV_STAGES; g++) begin : g_stage
    assign carry[g+1] = carry[g] & cnt_q[g];
    assign cnt_d[g]   = cnt_q[g] ^ carry[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign phase    = cnt_q;
  assign slot_clk = cnt_q[DIV_STAGES-1];

endmodule

// File: rtl/pws_write_decode.sv
module pws_write_decode
  import periph_wr_strobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cpu_bus_t bus,
  input  logic     start,
  output logic     wr_req,
  output logic     armed
);

  logic wr_raw, ds_idle_raw;
  logic wr_q, ds_idle_q, armed_q;
  logic wr_d, ds_idle_d, armed_d;

  always_comb begin
    wr_raw      = !bus.dev_n && !bus.rw && bus.target && (!bus.uds_n || !bus.lds_n);
    ds_idle_raw = bus.uds_n && bus.lds_n;
    wr_d        = wr_raw;
    ds_idle_d   = ds_idle_raw;
    armed_d     = armed_q;
    if (start)          armed_d = 1'b0;
    else if (ds_idle_q) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      ds_idle_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      wr_q      <= wr_d;
      ds_idle_q <= ds_idle_d;
      armed_q   <= armed_d;
    end
  end

  assign wr_req = wr_q;
  assign armed  = armed_q;

endmodule

// File: rtl/pws_strobe_timer.sv
module pws_strobe_timer #(
  parameter int PW       = 3,
  parameter int START_PH = 7,
  parameter int END_PH   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  input  logic          wr_req,
  input  logic          armed,
  output logic          start,
  output logic          cs_n
);

  localparam int SLOT_LEN = 1 << PW;
  localparam int FALL_PH  = (START_PH + 1) % SLOT_LEN;
  localparam int RISE_PH  = (END_PH + 1) % SLOT_LEN;

  logic cs_n_q, cs_n_d;

  always_comb begin
    start  = (phase == PW'(START_PH)) && wr_req && armed;
    cs_n_d = cs_n_q;
    if (start)                      cs_n_d = 1'b0;
    else if (phase == PW'(END_PH))  cs_n_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n_q <= 1'b1;
    else        cs_n_q <= cs_n_d;
  end

  assign cs_n = cs_n_q;

  // R4: the strobe only ever begins at the first phase of the CPU slot
  a_r4_fall_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> (phase == PW'(FALL_PH)));

  // R5: the strobe is always released by the slot counter, whatever the bus does
  a_r5_high_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PW'(RISE_PH)) |-> cs_n_q);

endmodule

// File: rtl/periph_wr_strobe.sv
module periph_wr_strobe
  import periph_wr_strobe_pkg::*;
#(
  parameter int DIV_STAGES  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic dev_n,
  input  logic rw,
  input  logic uds_n,
  input  logic lds_n,
  input  logic wr_target,
  output logic cs_n,
  output logic slot_clk
);

  localparam int SLOT_LEN = 1 << DIV_STAGES;
  localparam int START_PH = SLOT_LEN - 1;
  localparam int END_PH   = SLOT_LEN / 2 - 1;

  logic                  rst_s_n;
  logic [DIV_STAGES-1:0] phase;
  logic                  wr_req, armed, start;
  cpu_bus_t              bus;

  assign bus = '{dev_n: dev_n, rw: rw, uds_n: uds_n, lds_n: lds_n, target: wr_target};

  pws_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_fast), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  pws_slot_divider #(.DIV_STAGES(DIV_STAGES)) u_div (
    .clk(clk_fast), .rst_n(rst_s_n), .phase(phase), .slot_clk(slot_clk)
  );

  pws_write_decode u_dec (
    .clk(clk_fast), .rst_n(rst_s_n), .bus(bus), .start(start),
    .wr_req(wr_req), .armed(armed)
  );

  pws_strobe_timer #(.PW(DIV_STAGES), .START_PH(START_PH), .END_PH(END_PH)) u_tmr (
    .clk(clk_fast), .rst_n(rst_s_n), .phase(phase), .wr_req(wr_req),
    .armed(armed), .start(start), .cs_n(cs_n)
  );

  // R6: every strobe consumes an armed state
  a_r6_one_per_arm: assert property (@(posedge clk_fast) disable iff (!rst_s_n)
    $fell(cs_n) |-> $past(armed));

  // R3: a strobe is caused by a write decoded at the ports two fast cycles earlier
  a_r3_write_cause: assert property (@(posedge clk_fast) disable iff (!rst_s_n)
    $fell(cs_n) |-> $past(!rw && !dev_n && wr_target && !(uds_n && lds_n), 2));

endmodule

// File: tb/test_periph_wr_strobe.sv
module test_periph_wr_strobe;

  logic clk = 1'b0;
  logic rst_n, dev_n, rw, uds_n, lds_n, wr_target;
  logic cs_n, slot_clk;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #5 clk = ~clk;

  periph_wr_strobe i_periph_wr_strobe (
    .clk_fast(clk), .rst_n(rst_n), .dev_n(dev_n), .rw(rw), .uds_n(uds_n),
    .lds_n(lds_n), .wr_target(wr_target), .cs_n(cs_n), .slot_clk(slot_clk)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_idle();
    dev_n = 1'b1; rw = 1'b1; uds_n = 1'b1; lds_n = 1'b1; wr_target = 1'b0;
  endtask

  // Leaves the bench at the falling clock edge inside the cycle with phase p.
  task automatic goto_phase(input int p);
    logic prev;
    do begin
      prev = slot_clk;
      @(negedge clk);
    end while (!(prev && !slot_clk));
    repeat (p) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    bus_idle();
    repeat (4) begin
      @(negedge clk);
      chk("R1 cs_n in reset", cs_n, 1'b1);
      chk("R1 slot_clk in reset", slot_clk, 1'b0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_slot_clock();
    goto_phase(0);
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      chk("R2 slot_clk shape", slot_clk, ((i % 8) < 4) ? 1'b0 : 1'b1);
    end
  endtask

  // Write starting at phase p; data strobes released hold_rel cycles after the fall.
  task automatic t_write(input int p, input int hold_rel, input logic u, input logic l,
                         input string tag);
    int dly, hold, n;
    dly  = (p == 7) ? 9 : 8 - p;
    hold = dly + hold_rel;
    n    = (hold + 4 > dly + 8) ? hold + 4 : dly + 8;
    goto_phase(p);
    dev_n = 1'b0; rw = 1'b0; uds_n = u; lds_n = l; wr_target = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      chk(tag, cs_n, (i >= dly && i <= dly + 3) ? 1'b0 : 1'b1);
      if (i == hold) bus_idle();
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_no_strobe(input logic dv, input logic r, input logic u, input logic l,
                             input logic tg, input string tag);
    goto_phase(0);
    dev_n = dv; rw = r; uds_n = u; lds_n = l; wr_target = tg;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      chk(tag, cs_n, 1'b1);
    end
    bus_idle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_slot_clock();
    // R4 and R5: a write starting in each phase, strobes held past the release
    for (int p = 0; p < 8; p++)
      t_write(p, 6, (p % 3 == 1) ? 1'b1 : 1'b0, (p % 3 == 2) ? 1'b1 : 1'b0,
              "R4/R5 phase sweep");
    // R3: accesses that must not strobe
    t_no_strobe(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3 read");
    t_no_strobe(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R3 device deselected");
    t_no_strobe(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 other target");
    t_no_strobe(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R3 no data strobe");
    // R6: long-held bus cycle strobes once, then a new cycle re-arms
    t_write(3, 30, 1'b0, 1'b0, "R6 single strobe on long hold");
    t_write(5, 6, 1'b0, 1'b1, "R6 rearm after release");
    // R7: data strobes dropped mid-pulse do not change the pulse
    t_write(2, 1, 1'b0, 1'b0, "R7 early strobe release");
    t_write(7, 0, 1'b1, 1'b0, "R7 release at fall");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule